// File: doc/BRIEF.md
# Auto-Reload Up-Counting Timer

This block is an 8-bit timer that counts upward. Each count step is enabled by one of four slow rate strobes, which arrive from a prescaler outside the block. A two-bit select picks the active strobe, and a run control starts and stops counting. Software loads the timer through a 4-bit register interface. It first stages a low nibble, then writes a high nibble. The high-nibble write commits the full byte to the reload register and to the counter at the same time. The running count can be read back one nibble at a time.

When a step takes the count to all ones, the block raises a one-cycle interrupt request. On the next step after that, the counter reloads the stored value instead of wrapping through zero, so the interrupt period is set by the reload value. The timer has no notion of a low-power state. It keeps counting as long as the clock and strobes keep coming, so it works unchanged while the rest of the system is halted.

Top module: `reload_tick_timer`

## Requirements
- R1: After reset the count is 00 hex, the interrupt output is low, and both the staged low nibble and the reload value are 00 hex.
- R2: The two-bit rate select chooses which strobe advances the counter: 00 selects strobe bit 0 (2 Hz), 01 selects bit 1 (8 Hz), 10 selects bit 2 (32 Hz) and 11 selects bit 3 (256 Hz). Pulses on the strobes that are not selected have no effect on the count.
- R3: A selected strobe with run high, in a cycle with no high-nibble write, increments the count by one at the next clock edge.
- R4: While run is low, the count holds its value and strobes are ignored.
- R5: A low-nibble write only stages the nibble. The count does not change.
- R6: A high-nibble write loads {written nibble, staged nibble} into both the reload register and the count at the next edge. It wins over a strobe in the same cycle and never raises an interrupt.
- R7: The interrupt output is a single-cycle pulse. It is high in exactly the cycle in which a counting step has just made the count FF hex.
- R8: A counting step taken while the count is FF hex loads the reload value. If the reload value is itself FF hex, that step raises the interrupt again.
- R9: The read port returns the count's low nibble when the nibble select is 0 and its high nibble when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_stb | input | 4 | Rate strobes from the prescaler, one bit per rate |
| rate_sel | input | 2 | Selects the strobe that enables counting |
| run_en | input | 1 | Counting enabled when high |
| wr_lo | input | 1 | Stage the low nibble of the load value |
| wr_hi | input | 1 | Write the high nibble and commit the full load value |
| wr_data | input | 4 | Nibble data for writes |
| rd_hi | input | 1 | Read nibble select: 0 low, 1 high |
| rd_nib | output | 4 | Selected nibble of the count |
| count_q | output | 8 | Current count |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The properties assume that every control and strobe input holds a known, settled value at each rising edge. They also assume that a strobe seen at an edge belongs to that edge alone. The increment and hold properties compare the count only with the previous cycle, so they do not depend on how far apart the strobes are. The bench changes inputs only on falling edges and never asserts both write strobes in the same cycle. It also holds a strobe high for long runs on purpose, to exercise the full 00-to-FF sweep one step per cycle.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
   localparam int unsigned RTT_CNT_W     = 8;
   localparam int unsigned RTT_NIB_W     = 4;
   localparam int unsigned RTT_NUM_RATES = 4;

   // Per-cycle command presented to the counter core
   typedef struct packed {
      logic load;
      logic step;
   } rtt_ctl_t;
endpackage

// File: rtl/rtt_rate_mux.sv
module rtt_rate_mux #(
   parameter int unsigned NUM_RATES = 4,
   localparam int unsigned SEL_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
   input  logic [NUM_RATES-1:0] rate_stb,
   input  logic [SEL_W-1:0]     rate_sel,
   input  logic                 run_en,
   output logic                 step
);
   logic [NUM_RATES-1:0] hit;

   generate
      if (NUM_RATES == 1) begin : g_single
         assign hit = rate_stb;
      end else begin : g_decode
         for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
            assign hit[g] = rate_stb[g] && (rate_sel == SEL_W'(g));
         end
      end
   endgenerate

   assign step = run_en && (|hit);
endmodule

// File: rtl/rtt_reload_reg.sv
module rtt_reload_reg #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [NIB_W-1:0] wr_data,
   output logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] reload_q
);
   logic [NIB_W-1:0] stage_lo;

   assign load_val = {wr_data, stage_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_lo <= '0;
         reload_q <= '0;
      end else begin
         if (wr_lo) stage_lo <= wr_data;
         if (wr_hi) reload_q <= load_val;
      end
   end
endmodule

// File: rtl/rtt_up_counter.sv
module rtt_up_counter
   import rtt_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rtt_ctl_t         ctl,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count_q,
   output logic             irq_pulse
);
   logic [CNT_W-1:0] inc_val;
   logic [CNT_W-1:0] step_val;
   logic             at_top;

   assign inc_val  = count_q + 1'b1;
   assign at_top   = &count_q;
   assign step_val = at_top ? reload_val : inc_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q   <= '0;
         irq_pulse <= 1'b0;
      end else if (ctl.load) begin
         count_q   <= load_val;
         irq_pulse <= 1'b0;
      end else if (ctl.step) begin
         count_q   <= step_val;
         irq_pulse <= &step_val;
      end else begin
         irq_pulse <= 1'b0;
      end
   end
endmodule

// File: rtl/reload_tick_timer.sv
module reload_tick_timer
   import rtt_pkg::*;
#(
   parameter int unsigned CNT_W     = RTT_CNT_W,
   parameter int unsigned NIB_W     = RTT_NIB_W,
   parameter int unsigned NUM_RATES = RTT_NUM_RATES,
   localparam int unsigned SEL_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RATES-1:0] rate_stb,
   input  logic [SEL_W-1:0]     rate_sel,
   input  logic                 run_en,
   input  logic                 wr_lo,
   input  logic                 wr_hi,
   input  logic [NIB_W-1:0]     wr_data,
   input  logic                 rd_hi,
   output logic [NIB_W-1:0]     rd_nib,
   output logic [CNT_W-1:0]     count_q,
   output logic                 irq_pulse
);
   generate
      if (CNT_W != 2 * NIB_W) begin : g_bad_width
         $error("reload_tick_timer: CNT_W must be twice NIB_W");
      end
      if (NUM_RATES < 1) begin : g_bad_rates
         $error("reload_tick_timer: NUM_RATES must be at least 1");
      end
   endgenerate

   rtt_ctl_t         ctl;
   logic             step;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] reload_q;

   rtt_rate_mux #(.NUM_RATES(NUM_RATES)) u_mux (
      .rate_stb (rate_stb),
      .rate_sel (rate_sel),
      .run_en   (run_en),
      .step     (step)
   );

   rtt_reload_reg #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_reload (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wr_data  (wr_data),
      .load_val (load_val),
      .reload_q (reload_q)
   );

   assign ctl.load = wr_hi;
   assign ctl.step = step;

   rtt_up_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (ctl),
      .load_val   (load_val),
      .reload_val (reload_q),
      .count_q    (count_q),
      .irq_pulse  (irq_pulse)
   );

   assign rd_nib = rd_hi ? count_q[CNT_W-1:NIB_W] : count_q[NIB_W-1:0];
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned NUM_RATES = 4,
   parameter int unsigned SEL_W     = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_RATES-1:0] rate_stb,
   input logic [SEL_W-1:0]     rate_sel,
   input logic                 run_en,
   input logic                 wr_hi,
   input logic [NIB_W-1:0]     wr_data,
   input logic [CNT_W-1:0]     count_q,
   input logic                 irq_pulse
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic sel_stb;
   assign sel_stb = rate_stb[rate_sel];

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && sel_stb && !wr_hi && count_q != TOP)
      |=> count_q == CNT_W'($past(count_q) + 1'b1));

   assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !wr_hi) |=> $stable(count_q));

   assert_load_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (count_q[CNT_W-1:NIB_W] == $past(wr_data)) && !irq_pulse);

   assert_irq_at_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> count_q == TOP);

   assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse && !(run_en && sel_stb)) |=> !irq_pulse);

   assert_no_step_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_en && sel_stb) |=> !irq_pulse);
endmodule

bind reload_tick_timer rtt_checker #(
   .CNT_W(CNT_W), .NIB_W(NIB_W), .NUM_RATES(NUM_RATES), .SEL_W(SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rate_stb  (rate_stb),
   .rate_sel  (rate_sel),
   .run_en    (run_en),
   .wr_hi     (wr_hi),
   .wr_data   (wr_data),
   .count_q   (count_q),
   .irq_pulse (irq_pulse)
);

// File: tb/sim_reload_tick_timer.sv
`timescale 1ns/1ps
module sim_reload_tick_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] rate_stb = '0;
   logic [1:0] rate_sel = '0;
   logic       run_en = 1'b0;
   logic       wr_lo = 1'b0;
   logic       wr_hi = 1'b0;
   logic [3:0] wr_data = '0;
   logic       rd_hi = 1'b0;
   logic [3:0] rd_nib;
   logic [7:0] count_q;
   logic       irq_pulse;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   reload_tick_timer u0 (
      .clk(clk), .rst_n(rst_n), .rate_stb(rate_stb), .rate_sel(rate_sel),
      .run_en(run_en), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
      .rd_hi(rd_hi), .rd_nib(rd_nib), .count_q(count_q), .irq_pulse(irq_pulse)
   );

   // Fields: req[25:22] run[21] sel[20:19] stb[18:15] wlo[14] whi[13]
   //         data[12:9] exp_count[8:1] exp_irq[0]
   localparam int NV = 14;
   localparam logic [25:0] VEC [NV] = '{
      {4'd5, 1'b0, 2'd0, 4'b0000, 1'b1, 1'b0, 4'hE, 8'h00, 1'b0}, // R5 stage
      {4'd6, 1'b0, 2'd0, 4'b0000, 1'b0, 1'b1, 4'hF, 8'hFE, 1'b0}, // R6 commit
      {4'd7, 1'b1, 2'd0, 4'b0001, 1'b0, 1'b0, 4'h0, 8'hFF, 1'b1}, // R7 reach FF
      {4'd7, 1'b1, 2'd0, 4'b0000, 1'b0, 1'b0, 4'h0, 8'hFF, 1'b0}, // R7 pulse ends
      {4'd8, 1'b1, 2'd0, 4'b0001, 1'b0, 1'b0, 4'h0, 8'hFE, 1'b0}, // R8 reload
      {4'd2, 1'b1, 2'd1, 4'b0001, 1'b0, 1'b0, 4'h0, 8'hFE, 1'b0}, // R2 wrong tap
      {4'd2, 1'b1, 2'd1, 4'b0010, 1'b0, 1'b0, 4'h0, 8'hFF, 1'b1}, // R2 tap 01
      {4'd4, 1'b0, 2'd1, 4'b0010, 1'b0, 1'b0, 4'h0, 8'hFF, 1'b0}, // R4 stopped
      {4'd2, 1'b1, 2'd2, 4'b0100, 1'b0, 1'b0, 4'h0, 8'hFE, 1'b0}, // R2 tap 10
      {4'd2, 1'b1, 2'd3, 4'b1000, 1'b0, 1'b0, 4'h0, 8'hFF, 1'b1}, // R2 tap 11
      {4'd2, 1'b1, 2'd3, 4'b0111, 1'b0, 1'b0, 4'h0, 8'hFF, 1'b0}, // R2 others
      {4'd5, 1'b0, 2'd3, 4'b0000, 1'b1, 1'b0, 4'h3, 8'hFF, 1'b0}, // R5 no change
      {4'd6, 1'b1, 2'd3, 4'b1000, 1'b0, 1'b1, 4'h1, 8'h13, 1'b0}, // R6 load wins
      {4'd3, 1'b1, 2'd3, 4'b1000, 1'b0, 1'b0, 4'h0, 8'h14, 1'b0}  // R3 increment
   };

   task automatic check(input string req, input logic [7:0] act,
                        input logic [7:0] exp, input logic act_i, input logic exp_i);
      n_chk++;
      if (act !== exp || act_i !== exp_i) begin
         n_bad++;
         $display("FAIL %s: count=%h irq=%b expected count=%h irq=%b",
                  req, act, act_i, exp, exp_i);
      end
   endtask

   task automatic drive(input logic run, input logic [1:0] sel, input logic [3:0] stb,
                        input logic wl, input logic wh, input logic [3:0] d);
      run_en = run; rate_sel = sel; rate_stb = stb;
      wr_lo = wl; wr_hi = wh; wr_data = d;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", count_q, 8'h00, irq_pulse, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [25:0] v;
         v = VEC[i];
         drive(v[21], v[20:19], v[18:15], v[14], v[13], v[12:9]);
         @(negedge clk);
         check($sformatf("R%0d", v[25:22]), count_q, v[8:1], irq_pulse, v[0]);
      end
      drive(1'b0, 2'd0, 4'b0000, 1'b0, 1'b0, 4'h0);

      // R9 nibble readback of count 14
      rd_hi = 1'b0; #1;
      check("R9", {4'h0, rd_nib}, 8'h04, 1'b0, 1'b0);
      rd_hi = 1'b1; #1;
      check("R9", {4'h0, rd_nib}, 8'h01, 1'b0, 1'b0);
      @(negedge clk);

      // R8 reload value FF: every step re-raises the interrupt
      drive(1'b0, 2'd3, 4'b0000, 1'b1, 1'b0, 4'hF); @(negedge clk);
      drive(1'b0, 2'd3, 4'b0000, 1'b0, 1'b1, 4'hF); @(negedge clk);
      check("R6", count_q, 8'hFF, irq_pulse, 1'b0);
      drive(1'b1, 2'd3, 4'b1000, 1'b0, 1'b0, 4'h0); @(negedge clk);
      check("R8", count_q, 8'hFF, irq_pulse, 1'b1);
      @(negedge clk);
      check("R8", count_q, 8'hFF, irq_pulse, 1'b1);

      // R3 full sweep from 00 to FF, then reload to 00
      drive(1'b0, 2'd0, 4'b0000, 1'b1, 1'b0, 4'h0); @(negedge clk);
      drive(1'b0, 2'd0, 4'b0000, 1'b0, 1'b1, 4'h0); @(negedge clk);
      drive(1'b1, 2'd0, 4'b0001, 1'b0, 1'b0, 4'h0);
      repeat (255) @(negedge clk);
      check("R3", count_q, 8'hFF, irq_pulse, 1'b1);
      @(negedge clk);
      check("R8", count_q, 8'h00, irq_pulse, 1'b0);
      drive(1'b0, 2'd0, 4'b0000, 1'b0, 1'b0, 4'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule